// File: doc/BRIEF.md
# Vector Writeback Exception Substitution and Summary Unit

This unit sits at the writeback stage of a vector arithmetic pipeline. Each cycle it may receive one element result, together with the result's data class (integer or floating) and the exception flags that the arithmetic stage raised. It never stops the instruction. Every element is written. A faulting element is replaced by a default value that depends on its exception class.

Every exception that counts also leaves a sticky trace in a summary register. That register holds one bit per exception type and a one-hot mask of the destination vector registers that took an exception. The status logic reads the summary, and a clear command from that side empties it. A single-cycle pulse tells the status logic that an arithmetic exception was recorded, so that it can raise its exception flag and stop issue to the vector unit.

Top module: `vexc_wb_unit`

## Requirements
- R1: Each cycle with `elem_valid` high produces `out_valid` high one clock later, whatever the flags are. A cycle with `elem_valid` low produces `out_valid` low one clock later.
- R2: An integer element (`is_float`=0) is written as the low ELEM_W bits of `res_in`. This holds with or without integer overflow. Overflow sets summary bit 0.
- R3: A floating element (`is_float`=1) with no active flag is written as the low ELEM_W bits of `res_in`, and nothing is recorded.
- R4: A floating element whose only flag is underflow, with `unf_en`=0, is written as zero. It sets no summary bit and gives no pulse.
- R5: A floating element with divide by zero, overflow, reserved operand, or underflow with `unf_en`=1 is written as the reserved-operand code. That code has the top bit (sign) set and every other bit clear (0x80000000 for 32 bits).
- R6: The summary type bits are sticky and sit at fixed positions: bit 0 integer overflow, bit 1 enabled floating underflow, bit 2 floating overflow, bit 3 divide by zero, bit 4 reserved operand. All flags of one element are recorded together.
- R7: When an element records any exception, summary bit 5+`dest_reg` is set and stays set.
- R8: `exc_pulse` is high for exactly the output cycle of an element that recorded at least one exception, and low otherwise.
- R9: `clr_cmd` zeroes the summary at the next clock edge. If an exception is recorded in the same cycle, only that new exception remains afterwards.
- R10: The floating flags have no effect on an integer element, and the integer-overflow flag has no effect on a floating element.
- R11: While `rst_n` is low, `out_valid`, `exc_pulse` and `summary` are zero after the clock edge.
- R12: Flags presented with `elem_valid` low change neither the summary nor the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elem_valid | input | 1 | An element result is present this cycle |
| res_in | input | RES_W | True result from the arithmetic stage |
| is_float | input | 1 | 1 for a floating element, 0 for integer |
| f_iovf | input | 1 | Integer overflow flag |
| f_unf | input | 1 | Floating underflow flag |
| f_ovf | input | 1 | Floating overflow flag |
| f_dz | input | 1 | Floating divide-by-zero flag |
| f_rop | input | 1 | Reserved-operand input flag |
| unf_en | input | 1 | Underflow exceptions enabled |
| dest_reg | input | IDX_W | Destination vector register index |
| clr_cmd | input | 1 | Clear the summary register |
| out_valid | output | 1 | Element value to write is valid |
| out_elem | output | ELEM_W | Element value to write |
| exc_pulse | output | 1 | An arithmetic exception was recorded |
| summary | output | 5+NREG | Sticky type bits [4:0], destination mask above |

## Verification
The bench builds the unit with its default parameters: a 64-bit true result, a 32-bit element and 16 destination registers. A 64-bit result lets the integer truncation be checked with nonzero upper bits. A 32-bit element makes the reserved-operand code a known constant, 0x80000000. Sixteen registers give a 21-bit summary, so every mask position, including the top one, V15, can be set and checked. Directed sequences cover each flag alone and in combination, the underflow-enable split, flags crossed with the wrong data class, and clears with and without a same-cycle exception. A long random run then compares every cycle against a behavioural model.

// File: rtl/vexc_pkg.sv
// Package: shared positions and selector type for the writeback exception unit.
// Assumes: summary type bits occupy the low N_XTYPE positions.
package vexc_pkg;
    localparam int X_IOVF  = 0;
    localparam int X_FUNF  = 1;
    localparam int X_FOVF  = 2;
    localparam int X_FDZ   = 3;
    localparam int X_ROP   = 4;
    localparam int N_XTYPE = 5;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_ZERO = 2'd1,
        SEL_RSV  = 2'd2
    } subst_sel_t;
endpackage

// File: rtl/vexc_classify.sv
// Module: vexc_classify
// Decides which exception types an element records and which value replaces it.
// Assumes: flags arrive packed by the positions in vexc_pkg; purely combinational.
module vexc_classify
    import vexc_pkg::*;
(
    input  logic                 valid,
    input  logic                 is_float,
    input  logic [N_XTYPE-1:0]   flags,
    input  logic                 unf_en,
    output logic [N_XTYPE-1:0]   rec_types,
    output subst_sel_t           sel
);
    logic fv;
    logic hard_fault;

    // Record mask: an integer element may only overflow; quiet underflow is not recorded.
    always_comb begin
        fv = valid & is_float;
        rec_types          = '0;
        rec_types[X_IOVF]  = valid & ~is_float & flags[X_IOVF];
        rec_types[X_FUNF]  = fv & flags[X_FUNF] & unf_en;
        rec_types[X_FOVF]  = fv & flags[X_FOVF];
        rec_types[X_FDZ]   = fv & flags[X_FDZ];
        rec_types[X_ROP]   = fv & flags[X_ROP];
    end

    // Value selection: a hard fault beats quiet underflow, which beats pass-through.
    always_comb begin
        hard_fault = flags[X_FOVF] | flags[X_FDZ] | flags[X_ROP] |
                     (flags[X_FUNF] & unf_en);
        if (!is_float)
            sel = SEL_PASS;
        else if (hard_fault)
            sel = SEL_RSV;
        else if (flags[X_FUNF])
            sel = SEL_ZERO;
        else
            sel = SEL_PASS;
    end
endmodule

// File: rtl/vexc_subst.sv
// Module: vexc_subst
// Builds the element value to write from the true result and the selector.
// Assumes: RES_W >= ELEM_W; the reserved code is sign set, all else clear.
module vexc_subst
    import vexc_pkg::*;
#(
    parameter int RES_W  = 64,
    parameter int ELEM_W = 32
) (
    input  logic [RES_W-1:0]  res,
    input  subst_sel_t        sel,
    output logic [ELEM_W-1:0] elem
);
    localparam logic [ELEM_W-1:0] RSV_CODE = {1'b1, {(ELEM_W-1){1'b0}}};

    // Output mux: truncated result, zero, or reserved-operand code.
    always_comb begin
        case (sel)
            SEL_ZERO: elem = '0;
            SEL_RSV:  elem = RSV_CODE;
            default:  elem = res[ELEM_W-1:0];
        endcase
    end
endmodule

// File: rtl/vexc_record.sv
// Module: vexc_record
// Sticky summary register: type bits low, one-hot destination mask above.
// Assumes: a clear in the same cycle as a new record keeps only the new record.
module vexc_record
    import vexc_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG),
    parameter int SUM_W = N_XTYPE + NREG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_XTYPE-1:0] rec_types,
    input  logic [IDX_W-1:0]   dest_reg,
    input  logic               clr,
    output logic [SUM_W-1:0]   summary
);
    logic            any_rec;
    logic [NREG-1:0] dest_hit;

    assign any_rec = |rec_types;

    // One decoder slice per destination register.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign dest_hit[g] = any_rec && (dest_reg == IDX_W'(g));
    end

    // Summary update: optional clear, then merge this cycle's record.
    always_ff @(posedge clk) begin
        if (!rst_n)
            summary <= '0;
        else
            summary <= (clr ? '0 : summary) | {dest_hit, rec_types};
    end
endmodule

// File: rtl/vexc_wb_unit.sv
// Module: vexc_wb_unit (top)
// Writeback exception unit: substitutes default values for faulting elements,
// records exception types and destination registers, and pulses on a record.
// Assumes: one element per cycle; outputs registered, one cycle of latency.
module vexc_wb_unit
    import vexc_pkg::*;
#(
    parameter int RES_W  = 64,
    parameter int ELEM_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int SUM_W = N_XTYPE + NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_valid,
    input  logic [RES_W-1:0]  res_in,
    input  logic              is_float,
    input  logic              f_iovf,
    input  logic              f_unf,
    input  logic              f_ovf,
    input  logic              f_dz,
    input  logic              f_rop,
    input  logic              unf_en,
    input  logic [IDX_W-1:0]  dest_reg,
    input  logic              clr_cmd,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_elem,
    output logic              exc_pulse,
    output logic [SUM_W-1:0]  summary
);
    logic [N_XTYPE-1:0] flags;
    logic [N_XTYPE-1:0] rec_types;
    subst_sel_t         sel;
    logic [ELEM_W-1:0]  elem_nxt;

    // Pack the flags by their summary positions.
    always_comb begin
        flags         = '0;
        flags[X_IOVF] = f_iovf;
        flags[X_FUNF] = f_unf;
        flags[X_FOVF] = f_ovf;
        flags[X_FDZ]  = f_dz;
        flags[X_ROP]  = f_rop;
    end

    vexc_classify u_cls (
        .valid     (elem_valid),
        .is_float  (is_float),
        .flags     (flags),
        .unf_en    (unf_en),
        .rec_types (rec_types),
        .sel       (sel)
    );

    vexc_subst #(.RES_W(RES_W), .ELEM_W(ELEM_W)) u_sub (
        .res  (res_in),
        .sel  (sel),
        .elem (elem_nxt)
    );

    vexc_record #(.NREG(NREG), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_types (rec_types),
        .dest_reg  (dest_reg),
        .clr       (clr_cmd),
        .summary   (summary)
    );

    // Output stage: register the element, its valid and the exception pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_elem  <= '0;
            exc_pulse <= 1'b0;
        end else begin
            out_valid <= elem_valid;
            out_elem  <= elem_nxt;
            exc_pulse <= |rec_types;
        end
    end
endmodule

// File: rtl/vexc_wb_unit_chk.sv
// Module: vexc_wb_unit_chk
// Checker bound to vexc_wb_unit; watches its ports only.
module vexc_wb_unit_chk #(
    parameter int RES_W  = 64,
    parameter int ELEM_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int SUM_W = 5 + NREG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              elem_valid,
    input logic [RES_W-1:0]  res_in,
    input logic              is_float,
    input logic              f_iovf,
    input logic              f_unf,
    input logic              f_ovf,
    input logic              f_dz,
    input logic              f_rop,
    input logic              unf_en,
    input logic [IDX_W-1:0]  dest_reg,
    input logic              clr_cmd,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_elem,
    input logic              exc_pulse,
    input logic [SUM_W-1:0]  summary
);
    localparam logic [ELEM_W-1:0] RSV = {1'b1, {(ELEM_W-1){1'b0}}};

    // R1
    out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |=> out_valid);
    // R1
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid |=> !out_valid);
    // R4
    quiet_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && is_float && f_unf && !unf_en && !f_ovf && !f_dz && !f_rop)
        |=> (out_elem == '0) && !exc_pulse);
    // R5
    rsv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && is_float && (f_ovf || f_dz || f_rop || (f_unf && unf_en)))
        |=> (out_elem == RSV) && exc_pulse);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((summary & $past(summary)) == $past(summary)));
    // R8
    pulse_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> (out_valid && (summary != '0)));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !elem_valid) |=> (summary == '0));
    // R12
    no_rec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!elem_valid && !clr_cmd) |=> ($stable(summary) && !exc_pulse));
endmodule

bind vexc_wb_unit vexc_wb_unit_chk #(.RES_W(RES_W), .ELEM_W(ELEM_W), .NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .res_in(res_in),
    .is_float(is_float), .f_iovf(f_iovf), .f_unf(f_unf), .f_ovf(f_ovf),
    .f_dz(f_dz), .f_rop(f_rop), .unf_en(unf_en), .dest_reg(dest_reg),
    .clr_cmd(clr_cmd), .out_valid(out_valid), .out_elem(out_elem),
    .exc_pulse(exc_pulse), .summary(summary)
);

// File: tb/vexc_wb_unit_tb_top.sv
module vexc_wb_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        elem_valid = 1'b0;
    logic [63:0] res_in = '0;
    logic        is_float = 1'b0;
    logic        f_iovf = 1'b0, f_unf = 1'b0, f_ovf = 1'b0, f_dz = 1'b0, f_rop = 1'b0;
    logic        unf_en = 1'b0;
    logic [3:0]  dest_reg = '0;
    logic        clr_cmd = 1'b0;
    logic        out_valid;
    logic [31:0] out_elem;
    logic        exc_pulse;
    logic [20:0] summary;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model state
    bit          m_types[5];
    bit          m_mask[16];
    bit          m_valid;
    logic [31:0] m_elem;
    bit          m_pulse;

    always #5 clk = ~clk;

    vexc_wb_unit dut_i (
        .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .res_in(res_in),
        .is_float(is_float), .f_iovf(f_iovf), .f_unf(f_unf), .f_ovf(f_ovf),
        .f_dz(f_dz), .f_rop(f_rop), .unf_en(unf_en), .dest_reg(dest_reg),
        .clr_cmd(clr_cmd), .out_valid(out_valid), .out_elem(out_elem),
        .exc_pulse(exc_pulse), .summary(summary)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] model_sum();
        logic [20:0] s = '0;
        for (int i = 0; i < 5; i++) s[i] = m_types[i];
        for (int i = 0; i < 16; i++) s[5 + i] = m_mask[i];
        return s;
    endfunction

    // One element cycle: drive at negedge, advance model, compare at next negedge.
    task automatic step(input bit v, input bit isf, input bit iov, input bit unf,
                        input bit ovf, input bit dz, input bit rop, input bit ue,
                        input logic [63:0] r, input int d, input bit clr, input string tag);
        bit rec[5];
        bit anyrec;
        elem_valid = v; is_float = isf; f_iovf = iov; f_unf = unf; f_ovf = ovf;
        f_dz = dz; f_rop = rop; unf_en = ue; res_in = r; dest_reg = 4'(d); clr_cmd = clr;
        for (int i = 0; i < 5; i++) rec[i] = 0;
        if (v && !isf) begin
            rec[0] = iov;
            m_elem = r[31:0];
        end else if (v) begin
            rec[1] = unf && ue; rec[2] = ovf; rec[3] = dz; rec[4] = rop;
            if (ovf || dz || rop || (unf && ue)) m_elem = 32'h8000_0000;
            else if (unf)                        m_elem = 32'h0;
            else                                 m_elem = r[31:0];
        end
        anyrec = rec[0] || rec[1] || rec[2] || rec[3] || rec[4];
        if (clr) begin
            for (int i = 0; i < 5; i++) m_types[i] = 0;
            for (int i = 0; i < 16; i++) m_mask[i] = 0;
        end
        for (int i = 0; i < 5; i++) if (rec[i]) m_types[i] = 1;
        if (anyrec) m_mask[d] = 1;
        m_valid = v;
        m_pulse = anyrec;
        @(negedge clk);
        check({tag, " R1 valid"}, 64'(out_valid), 64'(m_valid));
        if (m_valid) check({tag, " elem"}, 64'(out_elem), 64'(m_elem));
        check({tag, " R8 pulse"}, 64'(exc_pulse), 64'(m_pulse));
        check({tag, " R6 R7 R9 summary"}, 64'(summary), 64'(model_sum()));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_types[i] = 0;
        for (int i = 0; i < 16; i++) m_mask[i] = 0;
        // R11: outputs cleared while reset is held, even with stimulus present
        elem_valid = 1; f_dz = 1; is_float = 1;
        repeat (3) @(negedge clk);
        check("R11 valid", 64'(out_valid), 0);
        check("R11 pulse", 64'(exc_pulse), 0);
        check("R11 summary", 64'(summary), 0);
        elem_valid = 0; f_dz = 0;
        rst_n = 1;
        //            v isf iov unf ovf dz rop ue result                 d  clr
        // R2: integer without and with overflow (upper bits dropped)
        step(1, 0, 0, 0, 0, 0, 0, 0, 64'h1234_5678_9abc_def0, 3, 0, "R2 int plain");
        step(1, 0, 1, 0, 0, 0, 0, 0, 64'hffff_0000_0000_0007, 2, 0, "R2 int overflow");
        // R3: float pass-through
        step(1, 1, 0, 0, 0, 0, 0, 0, 64'h0000_0000_4120_0000, 5, 0, "R3 float clean");
        // R4: quiet underflow -> zero, no record
        step(1, 1, 0, 1, 0, 0, 0, 0, 64'h0000_0000_0000_0011, 6, 0, "R4 quiet unf");
        // R5: each hard fault gives the reserved code
        step(1, 1, 0, 1, 0, 0, 0, 1, 64'h55, 7, 0, "R5 enabled unf");
        step(1, 1, 0, 0, 1, 0, 0, 0, 64'h66, 8, 0, "R5 overflow");
        step(1, 1, 0, 0, 0, 1, 0, 0, 64'h77, 9, 0, "R5 divzero");
        step(1, 1, 0, 0, 0, 0, 1, 0, 64'h88, 15, 0, "R5 rsvd operand");
        // R9: clear alone, then clear merged with new record
        step(0, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0, 1, "R9 clear");
        step(1, 1, 0, 0, 1, 1, 0, 0, 64'h99, 0, 1, "R9 clear+record R6 multi");
        // R10: cross-class flags ignored
        step(1, 0, 0, 1, 1, 1, 1, 1, 64'haaaa_bbbb_cccc_dddd, 4, 0, "R10 int with float flags");
        step(1, 1, 1, 0, 0, 0, 0, 0, 64'h1111_2222_3333_4444, 10, 0, "R10 float with iovf");
        // R12: flags without valid
        step(0, 1, 1, 1, 1, 1, 1, 1, 64'hdead, 11, 0, "R12 idle flags");
        step(0, 0, 1, 0, 0, 0, 0, 0, 64'hbeef, 12, 0, "R12 idle iovf");
        // R7: several destinations accumulate
        step(1, 0, 1, 0, 0, 0, 0, 0, 64'h1, 13, 0, "R7 dest 13");
        step(1, 0, 1, 0, 0, 0, 0, 0, 64'h2, 1, 0, "R7 dest 1");
        // random mixed traffic
        for (int k = 0; k < 600; k++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
                 $urandom_range(0, 6) == 0, $urandom_range(0, 6) == 0,
                 $urandom_range(0, 6) == 0, $urandom_range(0, 1) == 1,
                 {$urandom, $urandom}, $urandom_range(0, 15),
                 $urandom_range(0, 15) == 0, "R1 R5 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule